// File: doc/BRIEF.md
# Multichannel Service Request Aggregator

This block gathers per-channel service events from up to sixteen serial channels and sorts them into five request bitmaps. The classes are receive-ready, transmit-room, line-error, modem-change and command-complete. Bit n of every bitmap belongs to channel n. Receive-ready requests come from a receive fill level that climbs to a programmable trigger count. Transmit-room requests come from a transmit backlog that drains to a programmable low watermark. The other three classes arrive as single-cycle pulses from the channel engines.

A host reaches the block through a small register port. A plain write strobe changes configuration. An atomic swap strobe returns a bitmap and empties it in the same cycle. Any event that lands in that cycle is kept in the emptied bitmap.

One interrupt line tells the host that work is waiting. The host retires the interrupt in two steps: a doorbell clear, then a global acknowledge. The line cannot rise again until the acknowledge has been given. A per-channel mask decides which channels may raise the interrupt. Masked channels still record their request bits.

Top module: `svc_req_agg`

## Requirements
- R1: After reset all five request bitmaps read 0, `irq` is low, the channel mask (address 5) reads all ones, the receive trigger (address 6) reads 1 and the transmit low watermark (address 7) reads 64.
- R2: A pulse on bit n of `err_evt`, `mdm_evt` or `cmd_done` sets bit n of the error bitmap (address 2), the modem bitmap (address 3) or the command bitmap (address 4) after the next clock edge. The bit stays set until a swap of that address.
- R3: A swap (`bus_swap` high with `bus_addr` 0..4) puts the bitmap's current value on `bus_rdata` during that cycle and clears the bitmap at the edge. An event arriving in the swap cycle remains set afterwards.
- R4: Bit n of the receive bitmap (address 0) is set when `rx_level` of channel n goes from below the trigger to at least the trigger. The bit is not set again while the level stays at or above the trigger.
- R5: Bit n of the transmit bitmap (address 1) is set when `tx_level` of channel n goes from above the low watermark to at or below it.
- R6: An event on a channel whose mask bit is 1 raises `irq` after the next edge while the interrupt is armed. An event on a masked channel (mask bit 0) sets its bitmap bit and leaves `irq` low.
- R7: A write of a value with bit 0 set to address 8 (doorbell) drops `irq` after the next edge and disarms it. Later events do not raise `irq` until a global acknowledge is given. A write to address 9 of any value other than 0x0001 is not an acknowledge.
- R8: A write of 0x0001 to address 9 re-arms the interrupt. `irq` rises after that edge only if an unmasked event arrived since the doorbell clear. Otherwise it stays low until a new unmasked event arrives.
- R9: A plain write (`bus_wr`) to a request bitmap address leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | NCH*CNT_W | Receive fill level per channel, channel n at [n*CNT_W +: CNT_W] |
| tx_level | input | NCH*CNT_W | Transmit backlog per channel |
| err_evt | input | NCH | Line error pulse per channel |
| mdm_evt | input | NCH | Modem line change pulse per channel |
| cmd_done | input | NCH | Command completed pulse per channel |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Plain write strobe |
| bus_swap | input | 1 | Atomic read-and-clear strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Host interrupt |

## Verification
Every stored result is visible one edge after its cause. This covers a bitmap bit after its event or level crossing, the cleared bitmap after a swap, and `irq` after an event, a doorbell or an acknowledge. `bus_rdata` is combinational, so the old bitmap value is due in the swap cycle itself. The bench drives inputs at the falling edge. It samples `bus_rdata` shortly after that edge, before the rising edge consumes the swap. It samples stored state and `irq` one time unit after the rising edge.

// File: rtl/svc_req_pkg.sv
package svc_req_pkg;
   localparam int          BUS_W     = 16;
   localparam int          ADDR_W    = 4;
   localparam int          NUM_CLASS = 5;
   // request bitmaps sit at addresses equal to their class index
   localparam logic [3:0]  AD_RX     = 4'd0;
   localparam logic [3:0]  AD_TX     = 4'd1;
   localparam logic [3:0]  AD_ERR    = 4'd2;
   localparam logic [3:0]  AD_MDM    = 4'd3;
   localparam logic [3:0]  AD_CMD    = 4'd4;
   localparam logic [3:0]  AD_MASK   = 4'd5;
   localparam logic [3:0]  AD_RXTRIG = 4'd6;
   localparam logic [3:0]  AD_TXLOW  = 4'd7;
   localparam logic [3:0]  AD_DBELL  = 4'd8;
   localparam logic [3:0]  AD_GACK   = 4'd9;
   localparam logic [15:0] ACK_CODE  = 16'h0001;
endpackage

// File: rtl/svc_thresh_det.sv
module svc_thresh_det #(
   parameter int NCH     = 16,
   parameter int CNT_W   = 12,
   parameter bit FALLING = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH*CNT_W-1:0] level,
   input  logic [CNT_W-1:0]     thr,
   output logic [NCH-1:0]       evt
);
   logic [NCH-1:0] cond, cond_q;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      if (FALLING) begin : g_fall
         assign cond[ch] = level[ch*CNT_W +: CNT_W] <= thr;
      end else begin : g_rise
         assign cond[ch] = level[ch*CNT_W +: CNT_W] >= thr;
      end
   end

   // falling variant starts as already below, so an empty queue at reset is quiet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= {NCH{FALLING}};
      else        cond_q <= cond;
   end

   assign evt = cond & ~cond_q;
endmodule

// File: rtl/svc_req_word.sv
module svc_req_word #(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt,
   input  logic           swap_sel,
   output logic [NCH-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (swap_sel) word <= evt;
      else               word <= word | evt;
   end

   // R2
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_sel |=> (word & $past(word)) == $past(word));
   // R3
   swap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_sel && evt == '0) |=> word == '0);
endmodule

// File: rtl/svc_irq_ctl.sv
module svc_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic new_evt,
   input  logic db_clr,
   input  logic gack,
   output logic irq_o
);
   logic pend_q, armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         pend_q  <= (pend_q & ~db_clr) | new_evt;
         if (gack)        armed_q <= 1'b1;
         else if (db_clr) armed_q <= 1'b0;
      end
   end

   assign irq_o = pend_q & armed_q;

   // R7
   dbell_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_clr |=> !irq_o);
   // R8
   ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !gack) |=> !irq_o);
   // R6
   evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_evt && armed_q && !db_clr) |=> irq_o);
endmodule

// File: rtl/svc_req_agg.sv
module svc_req_agg
   import svc_req_pkg::*;
#(
   parameter int NCH       = 16,
   parameter int CNT_W     = 12,
   parameter int RXTRIG_RST = 1,
   parameter int TXLOW_RST  = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH*CNT_W-1:0] rx_level,
   input  logic [NCH*CNT_W-1:0] tx_level,
   input  logic [NCH-1:0]       err_evt,
   input  logic [NCH-1:0]       mdm_evt,
   input  logic [NCH-1:0]       cmd_done,
   input  logic [3:0]           bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_swap,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   output logic                 irq
);
   if (NCH < 1 || NCH > BUS_W) begin : g_bad_nch
      $error("svc_req_agg: NCH must lie in 1..16");
   end
   if (CNT_W < 7 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("svc_req_agg: CNT_W must lie in 7..16");
   end

   logic [NCH-1:0]                 mask_q;
   logic [CNT_W-1:0]               rxtrig_q, txlow_q;
   logic [NCH-1:0]                 rx_evt, tx_evt;
   logic [NUM_CLASS-1:0][NCH-1:0]  cls_evt, words;
   logic [NCH-1:0]                 evt_any;
   logic                           new_evt, db_clr, gack;

   svc_thresh_det #(.NCH(NCH), .CNT_W(CNT_W), .FALLING(1'b0)) i_rx_det (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rxtrig_q), .evt(rx_evt));
   svc_thresh_det #(.NCH(NCH), .CNT_W(CNT_W), .FALLING(1'b1)) i_tx_det (
      .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(txlow_q), .evt(tx_evt));

   assign cls_evt[AD_RX]  = rx_evt;
   assign cls_evt[AD_TX]  = tx_evt;
   assign cls_evt[AD_ERR] = err_evt;
   assign cls_evt[AD_MDM] = mdm_evt;
   assign cls_evt[AD_CMD] = cmd_done;

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      svc_req_word #(.NCH(NCH)) i_word (
         .clk(clk), .rst_n(rst_n), .evt(cls_evt[c]),
         .swap_sel(bus_swap && bus_addr == ADDR_W'(c)),
         .word(words[c]));
   end

   always_comb begin
      evt_any = '0;
      for (int c = 0; c < NUM_CLASS; c++) evt_any = evt_any | cls_evt[c];
   end
   assign new_evt = |(evt_any & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '1;
         rxtrig_q <= CNT_W'(RXTRIG_RST);
         txlow_q  <= CNT_W'(TXLOW_RST);
      end else if (bus_wr) begin
         case (bus_addr)
            AD_MASK:   mask_q   <= bus_wdata[NCH-1:0];
            AD_RXTRIG: rxtrig_q <= bus_wdata[CNT_W-1:0];
            AD_TXLOW:  txlow_q  <= bus_wdata[CNT_W-1:0];
            default:   ;
         endcase
      end
   end

   assign db_clr = bus_wr && bus_addr == AD_DBELL && bus_wdata[0];
   assign gack   = bus_wr && bus_addr == AD_GACK && bus_wdata == ACK_CODE;

   svc_irq_ctl i_irq (
      .clk(clk), .rst_n(rst_n), .new_evt(new_evt),
      .db_clr(db_clr), .gack(gack), .irq_o(irq));

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AD_RX, AD_TX, AD_ERR, AD_MDM, AD_CMD:
                    bus_rdata = BUS_W'(words[bus_addr[2:0]]);
         AD_MASK:   bus_rdata = BUS_W'(mask_q);
         AD_RXTRIG: bus_rdata = BUS_W'(rxtrig_q);
         AD_TXLOW:  bus_rdata = BUS_W'(txlow_q);
         default:   bus_rdata = '0;
      endcase
   end

   // R4
   rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt != '0 && !bus_swap) |=> (words[AD_RX] & $past(rx_evt)) == $past(rx_evt));
endmodule

// File: tb/test_svc_req_agg.sv
module test_svc_req_agg;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 16;
   localparam int CNT_W = 12;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NCH*CNT_W-1:0] rx_level = '0, tx_level = '0;
   logic [NCH-1:0]       err_evt = '0, mdm_evt = '0, cmd_done = '0;
   logic [3:0]           bus_addr = '0;
   logic                 bus_wr = 1'b0, bus_swap = 1'b0;
   logic [15:0]          bus_wdata = '0;
   logic [15:0]          bus_rdata;
   logic                 irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   svc_req_agg #(.NCH(NCH), .CNT_W(CNT_W)) i_svc_req_agg (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
      .err_evt(err_evt), .mdm_evt(mdm_evt), .cmd_done(cmd_done),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_swap(bus_swap),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // table: {bitmap address, channel}
   localparam logic [7:0] TBL [6] = '{8'h20, 8'h3F, 8'h47, 8'h29, 8'h40, 8'h33};

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic swap_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_swap = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_swap = 1'b0;
   endtask

   task automatic plain_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [3:0] a, input int ch);
      @(negedge clk);
      case (a)
         4'd2: err_evt[ch]  = 1'b1;
         4'd3: mdm_evt[ch]  = 1'b1;
         default: cmd_done[ch] = 1'b1;
      endcase
      @(posedge clk); #1;
      err_evt = '0; mdm_evt = '0; cmd_done = '0;
   endtask

   task automatic set_rx(input int ch, input int v);
      @(negedge clk);
      rx_level[ch*CNT_W +: CNT_W] = CNT_W'(v);
      @(posedge clk); #1;
   endtask

   task automatic set_tx(input int ch, input int v);
      @(negedge clk);
      tx_level[ch*CNT_W +: CNT_W] = CNT_W'(v);
      @(posedge clk); #1;
   endtask

   task automatic clean_irq;
      bus_write(4'd8, 16'h0001);
      bus_write(4'd9, 16'h0001);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      check("R1 irq", {15'd0, irq}, 16'h0000);
      for (int a = 0; a < 5; a++) begin
         swap_read(4'(a), d);
         check("R1 bitmap", d, 16'h0000);
      end
      plain_read(4'd5, d); check("R1 mask", d, 16'hFFFF);
      plain_read(4'd6, d); check("R1 rx trigger", d, 16'd1);
      plain_read(4'd7, d); check("R1 tx watermark", d, 16'd64);

      // R2/R3 table of pulse events
      for (int i = 0; i < 6; i++) begin
         pulse(TBL[i][7:4], int'(TBL[i][3:0]));
         swap_read(TBL[i][7:4], d);
         check("R2 event bit", d, 16'h0001 << TBL[i][3:0]);
         swap_read(TBL[i][7:4], d);
         check("R3 cleared by swap", d, 16'h0000);
      end

      // R2 stickiness across idle cycles
      pulse(4'd3, 11);
      repeat (4) @(posedge clk);
      swap_read(4'd3, d);
      check("R2 sticky", d, 16'h0800);

      // R3 event in swap cycle is kept
      pulse(4'd2, 5);
      @(negedge clk);
      bus_addr = 4'd2; bus_swap = 1'b1; err_evt[3] = 1'b1;
      #1 d = bus_rdata;
      check("R3 swap returns old", d, 16'h0020);
      @(posedge clk); #1;
      bus_swap = 1'b0; err_evt = '0;
      swap_read(4'd2, d);
      check("R3 same-cycle event kept", d, 16'h0008);

      // R9 plain write to a bitmap ignored
      pulse(4'd4, 2);
      bus_write(4'd4, 16'hFFFF);
      swap_read(4'd4, d);
      check("R9 write ignored", d, 16'h0004);
      bus_write(4'd4, 16'hFFFF);
      swap_read(4'd4, d);
      check("R9 write to empty ignored", d, 16'h0000);

      // R4 receive trigger crossing
      bus_write(4'd6, 16'd4);
      set_rx(2, 3);
      swap_read(4'd0, d); check("R4 below trigger", d, 16'h0000);
      set_rx(2, 4);
      swap_read(4'd0, d); check("R4 reaches trigger", d, 16'h0004);
      set_rx(2, 9);
      swap_read(4'd0, d); check("R4 no re-raise while above", d, 16'h0000);
      set_rx(2, 0);
      set_rx(2, 10);
      swap_read(4'd0, d); check("R4 second crossing", d, 16'h0004);

      // R5 transmit watermark crossing
      set_tx(5, 100);
      swap_read(4'd1, d); check("R5 above watermark", d, 16'h0000);
      set_tx(5, 65);
      swap_read(4'd1, d); check("R5 still above", d, 16'h0000);
      set_tx(5, 64);
      swap_read(4'd1, d); check("R5 reaches watermark", d, 16'h0020);

      // R6 masking
      clean_irq;
      check("R8 idle after ack", {15'd0, irq}, 16'h0000);
      bus_write(4'd5, 16'hFFEF);
      pulse(4'd3, 4);
      check("R6 masked no irq", {15'd0, irq}, 16'h0000);
      swap_read(4'd3, d); check("R6 masked bit recorded", d, 16'h0010);
      pulse(4'd3, 6);
      check("R6 unmasked irq", {15'd0, irq}, 16'h0001);
      swap_read(4'd3, d);

      // R7 doorbell and gating
      bus_write(4'd8, 16'h0001);
      check("R7 doorbell drops irq", {15'd0, irq}, 16'h0000);
      pulse(4'd4, 1);
      check("R7 disarmed stays low", {15'd0, irq}, 16'h0000);
      bus_write(4'd9, 16'h0003);
      check("R7 wrong ack code", {15'd0, irq}, 16'h0000);
      bus_write(4'd9, 16'h0001);
      check("R8 pending event after ack", {15'd0, irq}, 16'h0001);
      clean_irq;
      check("R8 no event stays low", {15'd0, irq}, 16'h0000);
      pulse(4'd2, 0);
      check("R8 new event after ack", {15'd0, irq}, 16'h0001);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule